// File: doc/BRIEF.md
# Multi-channel sync acquisition monitor

This block watches a group of serial receive lanes (four by default) and decides whether the group as a whole is synchronized. Each lane supplies a clock-recovery lock indication and, on every reference clock, one decoded byte with its K-character flag and decoder error flag. A global enable lets sync be acquired, and an active-low device reset forces the group out of sync.

Sync may only be acquired after every lane's recovered-clock lock has been held without a break for a programmable number of reference clocks. While that holds and the enable is high, every lane must show an acquisition pattern. A lane completes its pattern with four back-to-back commas or a run of sixteen clean K-characters. Once the group is synced, any lane that loses clock lock, shows a run of errored bytes, or shows too many errors inside a sixteen-byte block drops the whole group back to no-sync. The offending lanes are then marked in a sticky status vector.

Top module: `chsync_monitor`

## Requirements
- R1: While `dev_rst_n` is low at a rising clock edge, after that edge `in_sync`, `lock_qualified` and every bit of `los_status` are 0. The reset is synchronous.
- R2: `lock_qualified` is 1 only once every lane's `cdr_lock` has been sampled high on `qual_len` consecutive edges. It returns to 0 right after the edge at which any lane's `cdr_lock` is sampled low.
- R3: Hunting takes place only while `in_sync` is 0, `lock_qualified` is 1 and `chlock_en` is 1. A lane is ready once it sees one of two patterns: 4 consecutive commas, or 16 consecutive bytes that have `rx_kflag`=1 and `rx_err`=0. A comma is `rx_kflag`=1, `rx_err`=0 and byte value 8'hBC. Lane g's byte is `rx_byte[8g+7:8g]`. A ready lane stays ready while hunting continues. `in_sync` rises one edge after the edge at which the last lane became ready.
- R4: Sampling `chlock_en` low while synced clears `in_sync` after that edge and leaves `los_status` unchanged.
- R5: Sampling any lane's `cdr_lock` low while synced clears `in_sync` and sets that lane's `los_status` bit.
- R6: The fourth consecutive byte with `rx_err`=1 on a lane while synced clears `in_sync` and sets that lane's bit. Three consecutive errored bytes do not.
- R7: While synced, each lane's bytes fall into 16-byte blocks. Counting starts from the first synced byte and then wraps freely. A ninth errored byte inside one block clears `in_sync` and sets the lane's bit. Eight errors per block are tolerated.
- R8: An error-free byte resets a lane's consecutive-error run.
- R9: `los_status` bits stay set while out of sync and are all cleared on the edge that sets `in_sync`.
- R10: A non-matching byte, or any cycle with hunting suspended, discards a lane's partial acquisition progress and its ready mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| dev_rst_n | input | 1 | Synchronous active-low device reset |
| chlock_en | input | 1 | Permits sync acquisition and holding |
| qual_len | input | QUAL_W | Lock-stable cycles required per lane |
| cdr_lock | input | NCH | Per-lane clock-recovery lock |
| rx_byte | input | 8*NCH | Decoded bytes, lane g at bits 8g+7:8g |
| rx_kflag | input | NCH | Per-lane K-character flag |
| rx_err | input | NCH | Per-lane decoder error flag |
| in_sync | output | 1 | Group is synchronized |
| lock_qualified | output | 1 | All lanes have qualified lock |
| los_status | output | NCH | Sticky per-lane loss-of-sync cause |

## Verification
The hardest situation to reach is a loss caused only by the error rate inside one block, without the consecutive-error rule firing first. The stimulus gets there with a repeating error pattern whose period divides the block length. A two-errors-then-two-clean pattern lands exactly eight errors in every block, whatever its alignment to the sync entry, so it must be tolerated. A three-then-one pattern reaches a ninth error inside one block while never making a run of four. A mixed acquisition, with one lane using commas and the others the longer K-character run, checks that sync waits for the slowest lane.

// File: rtl/chsync_pkg.sv
package chsync_pkg;

    localparam logic [7:0] COMMA_BYTE = 8'hBC;

    typedef enum logic [0:0] {
        SYNC_LOST = 1'b0,
        SYNC_HELD = 1'b1
    } sync_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       kflag;
        logic       err;
    } rx_sym_t;

    typedef struct packed {
        logic consec;
        logic rate;
        logic cdr;
    } loss_cause_t;

    function automatic logic is_comma(rx_sym_t s);
        return s.kflag && !s.err && (s.data == COMMA_BYTE);
    endfunction

    function automatic logic is_kword(rx_sym_t s);
        return s.kflag && !s.err;
    endfunction

endpackage

// File: rtl/chsync_lock_qual.sv
module chsync_lock_qual #(
    parameter int QUAL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cdr_lock,
    input  logic [QUAL_W-1:0] qual_len,
    output logic              qual_ok
);
    logic [QUAL_W-1:0] stable_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            stable_cnt <= '0;
        end else if (!cdr_lock) begin
            stable_cnt <= '0;
        end else if (stable_cnt < qual_len) begin
            stable_cnt <= stable_cnt + QUAL_W'(1);
        end
    end

    assign qual_ok = !rst && (stable_cnt >= qual_len);

    // R2: a sampled lock drop withdraws qualification at once
    p_qual_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (!cdr_lock && qual_len != '0) |=> (!qual_ok || qual_len == '0));

endmodule

// File: rtl/chsync_lane.sv
module chsync_lane
    import chsync_pkg::*;
#(
    parameter int COMMA_RUN   = 4,
    parameter int KWORD_RUN   = 16,
    parameter int ERR_RUN     = 4,
    parameter int WIN_LEN     = 16,
    parameter int WIN_MAX_ERR = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  rx_sym_t     sym,
    input  logic        cdr_lock,
    input  logic        hunt,
    input  logic        track,
    output logic        ready,
    output logic        loss,
    output loss_cause_t cause
);
    localparam int CW = $clog2(COMMA_RUN + 1);
    localparam int KW = $clog2(KWORD_RUN + 1);
    localparam int EW = $clog2(ERR_RUN + 1);
    localparam int PW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int NW = $clog2(WIN_LEN + 1);

    logic [CW-1:0] comma_run;
    logic [KW-1:0] kword_run;
    logic [EW-1:0] err_run;
    logic [PW-1:0] win_pos;
    logic [NW-1:0] win_errs;
    logic          comma_hit;
    logic          kword_hit;
    logic          pattern_done;

    // acquisition side
    always_comb begin
        comma_hit    = is_comma(sym);
        kword_hit    = is_kword(sym);
        pattern_done = (comma_hit && comma_run == CW'(COMMA_RUN - 1)) ||
                       (kword_hit && kword_run == KW'(KWORD_RUN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !hunt) begin
            comma_run <= '0;
            kword_run <= '0;
            ready     <= 1'b0;
        end else begin
            if (!comma_hit)
                comma_run <= '0;
            else if (comma_run != CW'(COMMA_RUN))
                comma_run <= comma_run + CW'(1);
            if (!kword_hit)
                kword_run <= '0;
            else if (kword_run != KW'(KWORD_RUN))
                kword_run <= kword_run + KW'(1);
            ready <= ready || pattern_done;
        end
    end

    // monitoring side
    always_comb begin
        cause.cdr    = track && !cdr_lock;
        cause.consec = track && sym.err && (err_run == EW'(ERR_RUN - 1));
        cause.rate   = track && sym.err && (win_errs == NW'(WIN_MAX_ERR));
        loss         = cause.cdr || cause.consec || cause.rate;
    end

    always_ff @(posedge clk) begin
        if (rst || !track) begin
            err_run  <= '0;
            win_pos  <= '0;
            win_errs <= '0;
        end else begin
            if (!sym.err)
                err_run <= '0;
            else if (err_run != EW'(ERR_RUN))
                err_run <= err_run + EW'(1);
            if (win_pos == PW'(WIN_LEN - 1)) begin
                win_pos  <= '0;
                win_errs <= '0;
            end else begin
                win_pos  <= win_pos + PW'(1);
                win_errs <= win_errs + {{(NW-1){1'b0}}, sym.err};
            end
        end
    end

    // R6: while tracking, the run never reaches the loss length
    p_run_short_r6: assert property (@(posedge clk) disable iff (rst)
        track |-> (err_run < EW'(ERR_RUN)));

    // R7: while tracking, a block never holds more than the tolerated errors
    p_window_bound_r7: assert property (@(posedge clk) disable iff (rst)
        track |-> (win_errs <= NW'(WIN_MAX_ERR)));

    // R10: suspending the hunt drops the ready mark
    p_ready_drop_r10: assert property (@(posedge clk) disable iff (rst)
        !hunt |=> !ready);

endmodule

// File: rtl/chsync_monitor.sv
module chsync_monitor
    import chsync_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int QUAL_W      = 16,
    parameter int COMMA_RUN   = 4,
    parameter int KWORD_RUN   = 16,
    parameter int ERR_RUN     = 4,
    parameter int WIN_LEN     = 16,
    parameter int WIN_MAX_ERR = 8
) (
    input  logic              clk,
    input  logic              dev_rst_n,
    input  logic              chlock_en,
    input  logic [QUAL_W-1:0] qual_len,
    input  logic [NCH-1:0]    cdr_lock,
    input  logic [8*NCH-1:0]  rx_byte,
    input  logic [NCH-1:0]    rx_kflag,
    input  logic [NCH-1:0]    rx_err,
    output logic              in_sync,
    output logic              lock_qualified,
    output logic [NCH-1:0]    los_status
);
    logic          rst;
    sync_state_e   state;
    logic [NCH-1:0] qual_ok;
    logic [NCH-1:0] lane_ready;
    logic [NCH-1:0] lane_loss;
    logic          hunt;
    logic          track;
    rx_sym_t       lane_sym   [NCH];
    loss_cause_t   lane_cause [NCH];

    assign rst = !dev_rst_n;

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        assign lane_sym[g] = '{data: rx_byte[8*g +: 8], kflag: rx_kflag[g], err: rx_err[g]};

        chsync_lock_qual #(.QUAL_W(QUAL_W)) u_qual (
            .clk      (clk),
            .rst      (rst),
            .cdr_lock (cdr_lock[g]),
            .qual_len (qual_len),
            .qual_ok  (qual_ok[g])
        );

        chsync_lane #(
            .COMMA_RUN   (COMMA_RUN),
            .KWORD_RUN   (KWORD_RUN),
            .ERR_RUN     (ERR_RUN),
            .WIN_LEN     (WIN_LEN),
            .WIN_MAX_ERR (WIN_MAX_ERR)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .sym      (lane_sym[g]),
            .cdr_lock (cdr_lock[g]),
            .hunt     (hunt),
            .track    (track),
            .ready    (lane_ready[g]),
            .loss     (lane_loss[g]),
            .cause    (lane_cause[g])
        );
    end

    assign lock_qualified = &qual_ok;
    assign hunt           = (state == SYNC_LOST) && lock_qualified && chlock_en;
    assign track          = (state == SYNC_HELD);
    assign in_sync        = track;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SYNC_LOST;
            los_status <= '0;
        end else begin
            unique case (state)
                SYNC_LOST: begin
                    if (hunt && (&lane_ready)) begin
                        state      <= SYNC_HELD;
                        los_status <= '0;
                    end
                end
                SYNC_HELD: begin
                    if ((|lane_loss) || !chlock_en) begin
                        state      <= SYNC_LOST;
                        los_status <= los_status | lane_loss;
                    end
                end
                default: state <= SYNC_LOST;
            endcase
        end
    end

    // R3: entry into sync only with qualified lock and enable
    p_entry_gate_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> $past(lock_qualified && chlock_en));

    // R9: status is clear on entry to sync
    p_los_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> (los_status == '0));

    // R9: status bits are never lost while out of sync
    p_los_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!in_sync && $past(!in_sync)) |->
            ((los_status & $past(los_status)) == $past(los_status)));

    // R4: a dropped enable ends sync on the next edge
    p_en_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (in_sync && !chlock_en) |=> !in_sync);

endmodule

// File: tb/chsync_monitor_tb_top.sv
module chsync_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int QLEN       = 20;

    logic              clk       = 1'b0;
    logic              dev_rst_n = 1'b0;
    logic              chlock_en = 1'b0;
    logic [15:0]       qual_len  = 16'(QLEN);
    logic [NCH-1:0]    cdr_lock  = '0;
    logic [8*NCH-1:0]  rx_byte   = '0;
    logic [NCH-1:0]    rx_kflag  = '0;
    logic [NCH-1:0]    rx_err    = '0;
    logic              in_sync;
    logic              lock_qualified;
    logic [NCH-1:0]    los_status;

    int    n_vec  = 0;
    int    n_bad  = 0;
    string cur_req = "R1";
    bit    done   = 0;

    chsync_monitor dut_i (
        .clk            (clk),
        .dev_rst_n      (dev_rst_n),
        .chlock_en      (chlock_en),
        .qual_len       (qual_len),
        .cdr_lock       (cdr_lock),
        .rx_byte        (rx_byte),
        .rx_kflag       (rx_kflag),
        .rx_err         (rx_err),
        .in_sync        (in_sync),
        .lock_qualified (lock_qualified),
        .los_status     (los_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_lock [NCH];
    int m_comma [NCH];
    int m_kw [NCH];
    int m_rdy [NCH];
    int m_erun [NCH];
    int m_wpos [NCH];
    int m_werr [NCH];
    int m_sync = 0;
    int m_los  = 0;

    function automatic int model_qual();
        for (int c = 0; c < NCH; c++)
            if (m_lock[c] < int'(qual_len)) return 0;
        return 1;
    endfunction

    always begin
        @(posedge clk);
        if (!dev_rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_lock[c] = 0; m_comma[c] = 0; m_kw[c] = 0; m_rdy[c] = 0;
                m_erun[c] = 0; m_wpos[c] = 0; m_werr[c] = 0;
            end
            m_sync = 0; m_los = 0;
        end else begin
            int q, hunting, all_rdy, lost;
            q = model_qual();
            hunting = (m_sync == 0 && q == 1 && chlock_en) ? 1 : 0;
            all_rdy = 1;
            lost = 0;
            for (int c = 0; c < NCH; c++) begin
                if (m_rdy[c] == 0) all_rdy = 0;
                if (m_sync == 1 && (!cdr_lock[c] ||
                    (rx_err[c] && (m_erun[c] == 3 || m_werr[c] == 8))))
                    lost = lost | (1 << c);
            end
            for (int c = 0; c < NCH; c++) begin
                bit k, e, cm;
                k  = rx_kflag[c];
                e  = rx_err[c];
                cm = k && !e && (rx_byte[8*c +: 8] == 8'hBC);
                m_lock[c] = cdr_lock[c] ? ((m_lock[c] < int'(qual_len)) ? m_lock[c] + 1 : m_lock[c]) : 0;
                if (hunting == 1) begin
                    if ((cm && m_comma[c] == 3) || (k && !e && m_kw[c] == 15)) m_rdy[c] = 1;
                    m_comma[c] = cm ? ((m_comma[c] < 4) ? m_comma[c] + 1 : 4) : 0;
                    m_kw[c]    = (k && !e) ? ((m_kw[c] < 16) ? m_kw[c] + 1 : 16) : 0;
                end else begin
                    m_comma[c] = 0; m_kw[c] = 0; m_rdy[c] = 0;
                end
                if (m_sync == 1) begin
                    m_erun[c] = e ? ((m_erun[c] < 4) ? m_erun[c] + 1 : 4) : 0;
                    if (m_wpos[c] == 15) begin m_wpos[c] = 0; m_werr[c] = 0; end
                    else begin m_wpos[c] = m_wpos[c] + 1; m_werr[c] = m_werr[c] + int'(e); end
                end else begin
                    m_erun[c] = 0; m_wpos[c] = 0; m_werr[c] = 0;
                end
            end
            if (m_sync == 1) begin
                if (lost != 0 || !chlock_en) begin m_sync = 0; m_los = m_los | lost; end
            end else if (hunting == 1 && all_rdy == 1) begin
                m_sync = 1; m_los = 0;
            end
        end
        #(CLK_PERIOD/4);
        if (!done) begin
            n_vec++;
            if (int'(in_sync) != m_sync || int'(lock_qualified) != model_qual() ||
                int'(los_status) != m_los) begin
                n_bad++;
                $display("FAIL %s model compare: got sync=%0d qual=%0d los=%b, expected sync=%0d qual=%0d los=%b",
                         cur_req, in_sync, lock_qualified, los_status, m_sync, model_qual(), 4'(m_los));
            end
        end
    end

    task automatic expect_eq(input int act, input int exp, input string tag, input string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ch(input int c, input logic [7:0] b, input logic k, input logic e);
        rx_byte[8*c +: 8] = b;
        rx_kflag[c] = k;
        rx_err[c]   = e;
    endtask

    task automatic set_all(input logic [7:0] b, input logic k, input logic e);
        for (int c = 0; c < NCH; c++) set_ch(c, b, k, e);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        step(3);
        expect_eq(int'(in_sync), 0, "R1", "in_sync in reset");
        expect_eq(int'(lock_qualified), 0, "R1", "lock_qualified in reset");
        expect_eq(int'(los_status), 0, "R1", "los_status in reset");

        // R2: qualification window
        cur_req = "R2";
        dev_rst_n = 1'b1;
        cdr_lock  = '1;
        chlock_en = 1'b1;
        step(QLEN - 1);
        expect_eq(int'(lock_qualified), 0, "R2", "one cycle short of qual_len");
        step(1);
        expect_eq(int'(lock_qualified), 1, "R2", "after qual_len cycles");

        // R3: comma acquisition on all lanes
        cur_req = "R3";
        set_all(8'hBC, 1'b1, 1'b0);
        step(4);
        set_all(8'h00, 1'b0, 1'b0);
        expect_eq(int'(in_sync), 0, "R3", "sync right after fourth comma");
        step(1);
        expect_eq(int'(in_sync), 1, "R3", "sync one edge later");

        // R8: broken error runs are tolerated
        cur_req = "R8";
        for (int i = 0; i < 7; i++) begin
            set_ch(0, 8'h11, 1'b0, (i == 3) ? 1'b0 : 1'b1);
            step(1);
        end
        set_ch(0, 8'h00, 1'b0, 1'b0);
        step(1);
        expect_eq(int'(in_sync), 1, "R8", "three-error runs split by clean byte");
        step(12);

        // R6: four consecutive errors on lane 1
        cur_req = "R6";
        set_ch(1, 8'h22, 1'b0, 1'b1);
        step(3);
        expect_eq(int'(in_sync), 1, "R6", "three errors keep sync");
        step(1);
        set_ch(1, 8'h00, 1'b0, 1'b0);
        expect_eq(int'(in_sync), 0, "R6", "fourth error drops sync");
        expect_eq(int'(los_status), 2, "R6", "lane 1 flagged");

        // R9: sticky while out of sync
        cur_req = "R9";
        step(5);
        expect_eq(int'(los_status), 2, "R9", "status holds");

        // R3: mixed acquisition, slowest lane decides
        cur_req = "R3";
        for (int i = 0; i < 16; i++) begin
            if (i < 4) set_ch(0, 8'hBC, 1'b1, 1'b0);
            else       set_ch(0, 8'h00, 1'b0, 1'b0);
            for (int c = 1; c < NCH; c++) set_ch(c, 8'h3C, 1'b1, 1'b0);
            step(1);
        end
        set_all(8'h00, 1'b0, 1'b0);
        expect_eq(int'(in_sync), 0, "R3", "not yet synced after sixteenth K");
        step(1);
        expect_eq(int'(in_sync), 1, "R3", "sync after slowest lane");
        expect_eq(int'(los_status), 0, "R9", "status cleared on sync entry");

        // R7: eight errors per block tolerated, nine not
        cur_req = "R7";
        for (int i = 0; i < 32; i++) begin
            set_ch(2, 8'h44, 1'b0, ((i % 4) < 2) ? 1'b1 : 1'b0);
            step(1);
        end
        expect_eq(int'(in_sync), 1, "R7", "eight errors per block");
        for (int i = 0; i < 16; i++) begin
            set_ch(2, 8'h44, 1'b0, ((i % 4) < 3) ? 1'b1 : 1'b0);
            step(1);
        end
        set_ch(2, 8'h00, 1'b0, 1'b0);
        expect_eq(int'(in_sync), 0, "R7", "ninth error in a block");
        expect_eq(int'(los_status), 4, "R7", "lane 2 flagged");

        // R10: broken comma run and suspended hunt discard progress
        cur_req = "R10";
        set_all(8'hBC, 1'b1, 1'b0); step(3);
        set_all(8'h00, 1'b0, 1'b0); step(1);
        set_all(8'hBC, 1'b1, 1'b0); step(1);
        set_all(8'h00, 1'b0, 1'b0); step(3);
        expect_eq(int'(in_sync), 0, "R10", "broken comma run");
        set_all(8'hBC, 1'b1, 1'b0); step(3);
        chlock_en = 1'b0; step(1);
        chlock_en = 1'b1; step(1);
        set_all(8'h00, 1'b0, 1'b0); step(3);
        expect_eq(int'(in_sync), 0, "R10", "hunt suspended mid run");
        set_all(8'hBC, 1'b1, 1'b0); step(4);
        set_all(8'h00, 1'b0, 1'b0); step(1);
        expect_eq(int'(in_sync), 1, "R10", "clean run after discard");

        // R4: enable drop
        cur_req = "R4";
        chlock_en = 1'b0; step(1);
        expect_eq(int'(in_sync), 0, "R4", "enable drop clears sync");
        expect_eq(int'(los_status), 0, "R4", "enable drop flags no lane");
        chlock_en = 1'b1;
        set_all(8'hBC, 1'b1, 1'b0); step(4);
        set_all(8'h00, 1'b0, 1'b0); step(1);
        expect_eq(int'(in_sync), 1, "R4", "resync after enable returns");

        // R5: lane 3 loses clock lock
        cur_req = "R5";
        cdr_lock[3] = 1'b0; step(1);
        cdr_lock[3] = 1'b1;
        expect_eq(int'(in_sync), 0, "R5", "lock loss drops sync");
        expect_eq(int'(los_status), 8, "R5", "lane 3 flagged");
        expect_eq(int'(lock_qualified), 0, "R2", "qualification withdrawn");
        cur_req = "R2";
        step(QLEN - 1);
        expect_eq(int'(lock_qualified), 0, "R2", "requalify short");
        step(1);
        expect_eq(int'(lock_qualified), 1, "R2", "requalified");

        // R1: reset while synced
        cur_req = "R1";
        set_all(8'hBC, 1'b1, 1'b0); step(4);
        set_all(8'h00, 1'b0, 1'b0); step(1);
        expect_eq(int'(in_sync), 1, "R3", "synced before reset");
        dev_rst_n = 1'b0; step(1);
        expect_eq(int'(in_sync), 0, "R1", "reset clears sync");
        expect_eq(int'(lock_qualified), 0, "R1", "reset clears qualification");
        step(2);
        finish_run();
    end

endmodule